// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides a fast input clock by a programmable ratio. The output high time and the output low time are set on their own, each as a count of input-clock cycles minus one, so the ratio runs from 2 to 32 and the duty cycle can be chosen freely within it. The two count fields are copied into shadow registers only while a restart is held or at the end of each high phase. A configuration change therefore never cuts a phase short.

An active-low chip-level SYNC input restarts every divider that obeys it. While SYNC is held, the output rests at a chosen starting level. Once SYNC is released, the first edge of the output is delayed by a programmable skew, so dividers with different skews keep a fixed phase relationship. A divider can be set to ignore SYNC. In that case its counter runs on undisturbed, and while SYNC is low its output is driven to a static level that a configuration bit selects. A bypass mode routes the input clock straight to the output and keeps the counter idle.

Top module: `prog_clk_div`

## Requirements
- R1: Reset drives clk_out low and loads both shadow counts with 7. Until the first high phase ends, the divider uses these defaults whatever the count inputs hold.
- R2: In free running, each low phase of clk_out lasts cfg_lo_cnt+1 input cycles.
- R3: In free running, each high phase of clk_out lasts cfg_hi_cnt+1 input cycles.
- R4: While sync_n is sampled 0 with cfg_sync_ign=0, clk_out is held from the next rising edge at the start level: high when cfg_start_hi=1, low when it is 0. cfg_force_lvl has no effect in this case.
- R5: After sync_n returns to 1, the first change of clk_out happens on rising edge number cfg_skew + N + 1 after the last edge that sampled sync_n at 0. N is the count field of the start level.
- R6: The count inputs are copied only at the rising edge that ends a high phase, or on any edge during a SYNC or bypass hold. A change in the middle of a phase leaves that phase's length unchanged.
- R7: With cfg_sync_ign=1, SYNC neither restarts nor holds the counter. Rising edges of clk_out keep the same period alignment before and after a SYNC pulse.
- R8: With cfg_sync_ign=1 and sync_n sampled 0, clk_out equals cfg_force_lvl from the next rising edge.
- R9: With cfg_bypass=1, clk_out follows clk_in and the counter is held as in R4. When bypass is released, counting restarts as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Active-low chip-level restart |
| cfg_lo_cnt | input | W | Low-phase length minus one |
| cfg_hi_cnt | input | W | High-phase length minus one |
| cfg_bypass | input | 1 | Pass clk_in to the output and idle the counter |
| cfg_sync_ign | input | 1 | Make this divider ignore SYNC |
| cfg_force_lvl | input | 1 | Static output level while SYNC is ignored and low |
| cfg_start_hi | input | 1 | Start level after a restart (1 = high) |
| cfg_skew | input | W | Extra input cycles before the first output change |
| clk_out | output | 1 | Divided clock |

## Verification
The level held during SYNC appears one rising edge after sync_n is first sampled low. The first output transition after release lands on edge cfg_skew+N+1 after the last held edge. Every later phase lasts its count plus one edge. The bench samples registered results at falling edges only and counts those samples, so the expected number of samples before each transition is exactly skew plus count. Bypass is a combinational path, so it is sampled a quarter period after each edge of clk_in, in the middle of the high and the low half.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;
endpackage

// File: rtl/pcd_shadow.sv
module pcd_shadow #(
  parameter int W   = 4,
  parameter int DEF = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] hi_in,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q
);
  localparam logic [W-1:0] DEF_V = W'(DEF);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= DEF_V;
      hi_q <= DEF_V;
    end else if (load) begin
      lo_q <= lo_in;
      hi_q <= hi_in;
    end
  end

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({lo_q, hi_q}));
endmodule

// File: rtl/pcd_core.sv
module pcd_core
  import pcd_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         start_hi,
  input  logic [W-1:0] skew,
  input  logic [W-1:0] lo_lim,
  input  logic [W-1:0] hi_lim,
  output logic         lvl_nxt,
  output logic         bnd
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] dly_q;
  logic [W-1:0] dly_d;
  logic [W-1:0] lim;
  logic         at_end;
  lvl_e         lvl_q;
  lvl_e         lvl_d;

  always_comb begin
    lim    = (lvl_q == LVL_HI) ? hi_lim : lo_lim;
    at_end = (dly_q == '0) && (cnt_q == lim);
    bnd    = !hold && at_end && (lvl_q == LVL_HI);
    lvl_d  = lvl_q;
    cnt_d  = cnt_q;
    dly_d  = dly_q;
    if (hold) begin
      lvl_d = start_hi ? LVL_HI : LVL_LO;
      cnt_d = '0;
      dly_d = skew;
    end else if (dly_q != '0) begin
      dly_d = dly_q - 1'b1;
    end else if (at_end) begin
      lvl_d = (lvl_q == LVL_HI) ? LVL_LO : LVL_HI;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= LVL_LO;
      cnt_q <= '0;
      dly_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
      dly_q <= dly_d;
    end
  end

  assign lvl_nxt = (lvl_d == LVL_HI);

  // R2 R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim);

  // R4
  hold_level_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (lvl_q == ($past(start_hi) ? LVL_HI : LVL_LO)) && (cnt_q == '0)
             && (dly_q == $past(skew)));

  // R5
  skew_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && dly_q != '0) |=> (lvl_q == $past(lvl_q)) && (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/pcd_outsel.sv
module pcd_outsel (
  input  logic clk,
  input  logic rst,
  input  logic force_en,
  input  logic force_lvl,
  input  logic div_nxt,
  input  logic bypass,
  output logic clk_out
);
  logic o_q;

  always_ff @(posedge clk) begin
    if (rst) o_q <= 1'b0;
    else     o_q <= force_en ? force_lvl : div_nxt;
  end

  assign clk_out = bypass ? clk : o_q;

  // R8
  force_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    force_en |=> o_q == $past(force_lvl));
endmodule

// File: rtl/prog_clk_div.sv
module prog_clk_div #(
  parameter int W       = 4,
  parameter int DEF_CNT = 7
) (
  input  logic         clk_in,
  input  logic         rst,
  input  logic         sync_n,
  input  logic [W-1:0] cfg_lo_cnt,
  input  logic [W-1:0] cfg_hi_cnt,
  input  logic         cfg_bypass,
  input  logic         cfg_sync_ign,
  input  logic         cfg_force_lvl,
  input  logic         cfg_start_hi,
  input  logic [W-1:0] cfg_skew,
  output logic         clk_out
);
  logic         hold;
  logic         force_en;
  logic         bnd;
  logic         div_nxt;
  logic [W-1:0] lo_lim;
  logic [W-1:0] hi_lim;

  assign hold     = cfg_bypass || (!cfg_sync_ign && !sync_n);
  assign force_en = cfg_sync_ign && !sync_n;

  pcd_shadow #(.W(W), .DEF(DEF_CNT)) u_shadow (
    .clk   (clk_in),
    .rst   (rst),
    .load  (hold || bnd),
    .lo_in (cfg_lo_cnt),
    .hi_in (cfg_hi_cnt),
    .lo_q  (lo_lim),
    .hi_q  (hi_lim)
  );

  pcd_core #(.W(W)) u_core (
    .clk      (clk_in),
    .rst      (rst),
    .hold     (hold),
    .start_hi (cfg_start_hi),
    .skew     (cfg_skew),
    .lo_lim   (lo_lim),
    .hi_lim   (hi_lim),
    .lvl_nxt  (div_nxt),
    .bnd      (bnd)
  );

  pcd_outsel u_outsel (
    .clk       (clk_in),
    .rst       (rst),
    .force_en  (force_en),
    .force_lvl (cfg_force_lvl),
    .div_nxt   (div_nxt),
    .bypass    (cfg_bypass),
    .clk_out   (clk_out)
  );

  // R7
  ign_no_hold_chk: assert property (@(posedge clk_in) disable iff (rst)
    (cfg_sync_ign && !cfg_bypass) |-> !hold);
endmodule

// File: tb/test_prog_clk_div.sv
`timescale 1ns/1ps
module test_prog_clk_div;
  logic       clk = 1'b0;
  logic       rst;
  logic       sync_n;
  logic [3:0] cfg_lo;
  logic [3:0] cfg_hi;
  logic       cfg_bypass;
  logic       cfg_ign;
  logic       cfg_force;
  logic       cfg_start;
  logic [3:0] cfg_skew;
  logic       clk_out;
  int         tests = 0;
  int         fails = 0;
  bit         done  = 1'b0;

  always #10 clk = ~clk;

  prog_clk_div i_prog_clk_div (
    .clk_in(clk), .rst(rst), .sync_n(sync_n), .cfg_lo_cnt(cfg_lo), .cfg_hi_cnt(cfg_hi),
    .cfg_bypass(cfg_bypass), .cfg_sync_ign(cfg_ign), .cfg_force_lvl(cfg_force),
    .cfg_start_hi(cfg_start), .cfg_skew(cfg_skew), .clk_out(clk_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_len(input bit lvl, output int n);
    n = 0;
    while (clk_out === lvl && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measure_hl(output int hw, output int lw);
    int g = 0;
    while (clk_out !== 1'b0 && g < 100) begin g++; @(negedge clk); end
    g = 0;
    while (clk_out !== 1'b1 && g < 100) begin g++; @(negedge clk); end
    run_len(1'b1, hw);
    run_len(1'b0, lw);
  endtask

  task automatic test_reset();
    int hw, lw;
    rst = 1'b1; sync_n = 1'b1; cfg_lo = 4'd3; cfg_hi = 4'd3; cfg_bypass = 1'b0;
    cfg_ign = 1'b0; cfg_force = 1'b0; cfg_start = 1'b0; cfg_skew = 4'd0;
    repeat (3) @(negedge clk);
    chk("R1 output low in reset", int'(clk_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 output low after reset", int'(clk_out), 0);
    measure_hl(hw, lw);
    chk("R1 first high uses default count", hw, 8);
    chk("R6 low after boundary uses new count", lw, 4);
  endtask

  task automatic do_sync(input int lo, input int hi, input bit st, input int p, input bit frc);
    int n;
    int ns = st ? hi : lo;
    int no = st ? lo : hi;
    @(negedge clk);
    cfg_lo = 4'(lo); cfg_hi = 4'(hi); cfg_start = st; cfg_skew = 4'(p);
    cfg_ign = 1'b0; cfg_bypass = 1'b0; cfg_force = frc; sync_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 start level during SYNC", int'(clk_out), int'(st));
    sync_n = 1'b1;
    @(negedge clk);
    run_len(st, n);
    chk("R5 first transition after release", n, p + ns);
    run_len(!st, n);
    chk(st ? "R2 low width" : "R3 high width", n, no + 1);
    run_len(st, n);
    chk(st ? "R3 high width" : "R2 low width", n, ns + 1);
  endtask

  task automatic test_random();
    for (int i = 0; i < 8; i++) begin
      do_sync($urandom_range(15, 0), $urandom_range(15, 0), 1'($urandom_range(1, 0)),
              $urandom_range(15, 0), 1'b0);
    end
  endtask

  task automatic test_skew();
    do_sync(2, 4, 1'b1, 0, 1'b0);
    do_sync(2, 4, 1'b1, 15, 1'b0);
    do_sync(0, 0, 1'b0, 5, 1'b1);
    do_sync(15, 15, 1'b0, 0, 1'b0);
  endtask

  task automatic test_midchange();
    int n;
    @(negedge clk);
    cfg_lo = 4'd3; cfg_hi = 4'd3; cfg_start = 1'b0; cfg_skew = 4'd0;
    cfg_ign = 1'b0; cfg_bypass = 1'b0; sync_n = 1'b0;
    repeat (2) @(negedge clk);
    sync_n = 1'b1;
    @(negedge clk);
    run_len(1'b0, n);
    chk("R5 first transition", n, 3);
    cfg_lo = 4'd1; cfg_hi = 4'd6;
    run_len(1'b1, n);
    chk("R6 current high keeps old count", n, 4);
    run_len(1'b0, n);
    chk("R6 next low uses new count", n, 2);
    run_len(1'b1, n);
    chk("R6 next high uses new count", n, 7);
  endtask

  task automatic test_ignore();
    int hw, lw;
    int t = 0;
    bit prev = 1'b1;
    bit seen = 1'b0;
    @(negedge clk);
    cfg_lo = 4'd2; cfg_hi = 4'd2; cfg_ign = 1'b1; cfg_force = 1'b1; cfg_bypass = 1'b0;
    measure_hl(hw, lw);
    measure_hl(hw, lw);
    chk("R7 free-running high", hw, 3);
    chk("R7 free-running low", lw, 3);
    repeat (3) begin @(negedge clk); t++; prev = clk_out; end
    sync_n = 1'b0;
    repeat (4) begin @(negedge clk); t++; prev = clk_out; end
    chk("R8 forced high during ignored SYNC", int'(clk_out), 1);
    sync_n = 1'b1;
    while (!seen && t < 100) begin
      @(negedge clk); t++;
      if (prev == 1'b0 && clk_out == 1'b1) seen = 1'b1;
      prev = clk_out;
    end
    chk("R7 period alignment kept across SYNC", t % 6, 0);
    cfg_force = 1'b0;
    sync_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 forced low during ignored SYNC", int'(clk_out), 0);
    sync_n = 1'b1;
    cfg_ign = 1'b0; cfg_force = 1'b1; cfg_start = 1'b0; sync_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 force has no effect when SYNC obeyed", int'(clk_out), 0);
    sync_n = 1'b1;
  endtask

  task automatic test_bypass();
    int n;
    @(negedge clk);
    cfg_lo = 4'd4; cfg_hi = 4'd1; cfg_start = 1'b1; cfg_skew = 4'd2;
    cfg_ign = 1'b0; cfg_force = 1'b0; cfg_bypass = 1'b1; sync_n = 1'b1;
    repeat (3) begin
      @(posedge clk); #5;
      chk("R9 bypass high half", int'(clk_out), 1);
      @(negedge clk); #5;
      chk("R9 bypass low half", int'(clk_out), 0);
    end
    @(negedge clk);
    cfg_bypass = 1'b0;
    @(negedge clk);
    run_len(1'b1, n);
    chk("R9 restart after bypass", n, 3);
    run_len(1'b0, n);
    chk("R9 low width after bypass", n, 5);
  endtask

  initial begin
    test_reset();
    test_skew();
    test_random();
    test_midchange();
    test_ignore();
    test_bypass();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule